// File: doc/BRIEF.md
# Programmable Horizontal Pulse Timing Generator

This block produces the line-rate timing pulses of a video front end: a fixed-width horizontal sync, an active-low blanking pulse, two clamp pulses and an active-low burst-key strobe. A pixel-rate clock drives it. A line-start strobe from an upstream phase-locked loop gives it the line reference. A horizontal position counter restarts at each line start, and every pulse is a window on that counter. The window edges come from register inputs.

The sync position moves in coarse steps of 8 clocks. The blanking, clamp and burst-key edges move in steps of 2 clocks. Settings are captured only at a line start, so a write in the middle of a line cannot cut a pulse short or repeat it. A field-blanking input marks the vertical interval. While it is high, the blanking edges keep the settings captured before it, so the vertical interval never disturbs the horizontal blanking timing.

Top module: `hpulse_gen`

## Requirements
- R1: `hs` is high for exactly 32 consecutive positions, unless the line ends first (see R7).
- R2: `hs` rises at position 8 × `hs_pos`.
- R3: `bln_n` falls at position 2 × `bln_start` and rises again at position 2 × `bln_stop`.
- R4: `h1` is high from position 2 × `h1_start` up to, but not including, 2 × `h1_stop`. `h2` behaves the same way with its own pair of settings.
- R5: `bkey_n` is low from position 2 × `bk_start` up to, but not including, 2 × `bk_stop`.
- R6: A pulse whose start setting is greater than or equal to its stop setting is never asserted.
- R7: The position counter saturates at LINE_LEN−1. A window whose end lies beyond LINE_LEN−1 stays active until the next line start.
- R8: All settings are captured when `line_start` is sampled high. A change at any other time has no effect until the next line start.
- R9: When `fld_blank` is high at a line start, the blanking settings are not recaptured. The other settings are recaptured as usual.
- R10: The clock edge that samples `line_start` high makes the next cycle position 0. The outputs are registered and show, in each cycle, the pulse levels for that cycle's position.
- R11: After reset, and until the first line start, `hs`, `h1` and `h2` are low and `bln_n` and `bkey_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle line reference strobe |
| fld_blank | input | 1 | High during the vertical blanking interval |
| hs_pos | input | CW-2 | Sync position, in units of 8 clocks |
| bln_start | input | CW | Blanking falling edge, in units of 2 clocks |
| bln_stop | input | CW | Blanking rising edge, in units of 2 clocks |
| h1_start | input | CW | Clamp 1 start, in units of 2 clocks |
| h1_stop | input | CW | Clamp 1 stop, in units of 2 clocks |
| h2_start | input | CW | Clamp 2 start, in units of 2 clocks |
| h2_stop | input | CW | Clamp 2 stop, in units of 2 clocks |
| bk_start | input | CW | Burst-key start, in units of 2 clocks |
| bk_stop | input | CW | Burst-key stop, in units of 2 clocks |
| hs | output | 1 | Horizontal sync, active high |
| bln_n | output | 1 | Blanking, active low |
| h1 | output | 1 | Clamp pulse 1, active high |
| h2 | output | 1 | Clamp pulse 2, active high |
| bkey_n | output | 1 | Inverted burst key |

## Verification
A wrong internal state shows up as a pulse edge at the wrong position. Because the outputs are registered from the next counter value, the error appears in the very cycle the faulty position is reached. A fault in the captured settings shows up only from the following line start, which is why the bench runs multi-line sequences. Mid-line writes and field-blanking lines are observed across a full line, so any leak of a new setting is visible as a shifted or missing edge within that line.

// File: rtl/hpulse_gen.sv
module hpulse_gen #(
  parameter int LINE_LEN = 864,
  localparam int CW  = $clog2(LINE_LEN),
  localparam int HPW = CW - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_start,
  input  logic           fld_blank,
  input  logic [HPW-1:0] hs_pos,
  input  logic [CW-1:0]  bln_start,
  input  logic [CW-1:0]  bln_stop,
  input  logic [CW-1:0]  h1_start,
  input  logic [CW-1:0]  h1_stop,
  input  logic [CW-1:0]  h2_start,
  input  logic [CW-1:0]  h2_stop,
  input  logic [CW-1:0]  bk_start,
  input  logic [CW-1:0]  bk_stop,
  output logic           hs,
  output logic           bln_n,
  output logic           h1,
  output logic           h2,
  output logic           bkey_n
);
  localparam int XW = CW + 3;
  localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

  logic [CW-1:0]  cnt, cnt_n;
  logic [HPW-1:0] hp_q, hp_n;
  logic [CW-1:0]  bs_q, be_q, h1s_q, h1e_q, h2s_q, h2e_q, ks_q, ke_q;
  logic [CW-1:0]  bs_n, be_n, h1s_n, h1e_n, h2s_n, h2e_n, ks_n, ke_n;
  logic [XW-1:0]  pos, hs_lo;

  function automatic logic win(input logic [XW-1:0] c, input logic [CW-1:0] s, input logic [CW-1:0] e);
    return (c >= XW'({s, 1'b0})) && (c < XW'({e, 1'b0}));
  endfunction

  assign cnt_n = line_start ? '0 : ((cnt == LAST) ? cnt : cnt + 1'b1);

  always_comb begin
    hp_n  = line_start ? hs_pos   : hp_q;
    h1s_n = line_start ? h1_start : h1s_q;
    h1e_n = line_start ? h1_stop  : h1e_q;
    h2s_n = line_start ? h2_start : h2s_q;
    h2e_n = line_start ? h2_stop  : h2e_q;
    ks_n  = line_start ? bk_start : ks_q;
    ke_n  = line_start ? bk_stop  : ke_q;
    bs_n  = (line_start && !fld_blank) ? bln_start : bs_q;
    be_n  = (line_start && !fld_blank) ? bln_stop  : be_q;
  end

  assign pos   = XW'(cnt_n);
  assign hs_lo = XW'({hp_n, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LAST;
      hp_q <= '0;
      {bs_q, be_q, h1s_q, h1e_q} <= '0;
      {h2s_q, h2e_q, ks_q, ke_q} <= '0;
      hs <= 1'b0;
      bln_n <= 1'b1;
      h1 <= 1'b0;
      h2 <= 1'b0;
      bkey_n <= 1'b1;
    end else begin
      cnt <= cnt_n;
      hp_q <= hp_n;
      {bs_q, be_q, h1s_q, h1e_q} <= {bs_n, be_n, h1s_n, h1e_n};
      {h2s_q, h2e_q, ks_q, ke_q} <= {h2s_n, h2e_n, ks_n, ke_n};
      hs <= (pos >= hs_lo) && (pos < hs_lo + XW'(32));
      bln_n <= !win(pos, bs_n, be_n);
      h1 <= win(pos, h1s_n, h1e_n);
      h2 <= win(pos, h2s_n, h2e_n);
      bkey_n <= !win(pos, ks_n, ke_n);
    end
  end
endmodule

module hpulse_gen_chk #(
  parameter int CW = 10,
  parameter int HPW = 8,
  parameter int LINE_LEN = 864
) (
  input logic           clk,
  input logic           rst_n,
  input logic           line_start,
  input logic           fld_blank,
  input logic [CW-1:0]  cnt,
  input logic [HPW-1:0] hp_q,
  input logic [CW-1:0]  bs_q,
  input logic [CW-1:0]  be_q,
  input logic [CW-1:0]  h1s_q,
  input logic [CW-1:0]  h1e_q,
  input logic           hs,
  input logic           h1
);
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) line_start |=> cnt == '0); // R10
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) <= LINE_LEN - 1); // R7
  AST_BLN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (line_start && fld_blank) |=> ($stable(bs_q) && $stable(be_q))); // R9
  AST_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n) !line_start |=> ($stable(hp_q) && $stable(h1s_q) && $stable(h1e_q))); // R8
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (h1s_q >= h1e_q) |-> !h1); // R6
  AST_HS_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n) hs |-> (int'(cnt) >= 8 * int'(hp_q))); // R2
  AST_HS_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n) hs |-> ((int'(cnt) < 8 * int'(hp_q) + 32) || (int'(cnt) == LINE_LEN - 1))); // R1
endmodule

bind hpulse_gen hpulse_gen_chk #(.CW(CW), .HPW(HPW), .LINE_LEN(LINE_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .fld_blank(fld_blank),
  .cnt(cnt), .hp_q(hp_q), .bs_q(bs_q), .be_q(be_q), .h1s_q(h1s_q), .h1e_q(h1e_q),
  .hs(hs), .h1(h1)
);

// File: tb/hpulse_gen_tb.sv
module hpulse_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN = 864;
  localparam int CW = $clog2(LINE_LEN);
  localparam int HPW = CW - 2;

  logic clk = 0, rst_n = 0, line_start = 0, fld_blank = 0;
  logic [HPW-1:0] hs_pos = '0;
  logic [CW-1:0] bln_start = '0, bln_stop = '0, h1_start = '0, h1_stop = '0;
  logic [CW-1:0] h2_start = '0, h2_stop = '0, bk_start = '0, bk_stop = '0;
  logic hs, bln_n, h1, h2, bkey_n;

  int checks = 0, errors = 0;
  int e_hp = 0, e_bs = 0, e_be = 0, e_1s = 0, e_1e = 0, e_2s = 0, e_2e = 0, e_ks = 0, e_ke = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpulse_gen #(.LINE_LEN(LINE_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .fld_blank(fld_blank),
    .hs_pos(hs_pos), .bln_start(bln_start), .bln_stop(bln_stop),
    .h1_start(h1_start), .h1_stop(h1_stop), .h2_start(h2_start), .h2_stop(h2_stop),
    .bk_start(bk_start), .bk_stop(bk_stop),
    .hs(hs), .bln_n(bln_n), .h1(h1), .h2(h2), .bkey_n(bkey_n)
  );

  function automatic logic [4:0] expv(input int k);
    int p;
    p = (k > LINE_LEN - 1) ? LINE_LEN - 1 : k;
    return {p >= 8*e_hp && p < 8*e_hp + 32,
            !(p >= 2*e_bs && p < 2*e_be),
            p >= 2*e_1s && p < 2*e_1e,
            p >= 2*e_2s && p < 2*e_2e,
            !(p >= 2*e_ks && p < 2*e_ke)};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos %0d: {hs,bln_n,h1,h2,bkey_n} actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic set_regs(input int hp, bs, be, a1, b1, a2, b2, ks, ke);
    hs_pos = HPW'(hp); bln_start = CW'(bs); bln_stop = CW'(be);
    h1_start = CW'(a1); h1_stop = CW'(b1); h2_start = CW'(a2); h2_stop = CW'(b2);
    bk_start = CW'(ks); bk_stop = CW'(ke);
  endtask

  // Runs one line of n positions; at position chg (if >=0) the settings are scrambled.
  task automatic run_line(input string req, input int n, input int chg);
    @(negedge clk);
    line_start = 1;
    e_hp = hs_pos; e_1s = h1_start; e_1e = h1_stop; e_2s = h2_start; e_2e = h2_stop;
    e_ks = bk_start; e_ke = bk_stop;
    if (!fld_blank) begin e_bs = bln_start; e_be = bln_stop; end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      line_start = 0;
      check(req, {hs, bln_n, h1, h2, bkey_n}, expv(k), k);
      if (k == chg) set_regs(3, 5, 9, 100, 101, 7, 300, 60, 70);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R11", {hs, bln_n, h1, h2, bkey_n}, 5'b01001, i);
    end
  endtask

  task automatic t_basic;
    set_regs(0, 10, 70, 20, 40, 60, 90, 30, 45);
    run_line("R1 R2 R3 R4 R5 R10", LINE_LEN, -1);
    set_regs(50, 300, 420, 5, 6, 200, 380, 411, 412);
    run_line("R1 R2 R3 R4 R5", LINE_LEN, -1);
  endtask

  task automatic t_degenerate;
    set_regs(105, 40, 40, 90, 30, 400, 1000, 431, 500);
    run_line("R6 R7", LINE_LEN + 20, -1);
  endtask

  task automatic t_latch;
    set_regs(20, 100, 200, 50, 80, 120, 140, 150, 170);
    run_line("R8", LINE_LEN, 10);
    run_line("R8", LINE_LEN, -1);
  endtask

  task automatic t_field;
    set_regs(10, 150, 250, 20, 30, 40, 50, 60, 70);
    run_line("R9", 600, -1);
    fld_blank = 1;
    set_regs(12, 5, 350, 22, 33, 44, 55, 66, 77);
    run_line("R9", 600, -1);
    fld_blank = 0;
    run_line("R9", 600, -1);
  endtask

  task automatic t_restart;
    set_regs(4, 20, 30, 2, 12, 3, 13, 18, 22);
    run_line("R10", 37, -1);
    run_line("R10", 120, -1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_degenerate();
    t_latch();
    t_field();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule